// File: doc/BRIEF.md
# Burst Receive-and-Echo Controller

This controller sits on the parallel side of a simple byte-wide UART that reports a received byte with a data-available flag and a free transmitter with an empty flag. It gathers a fixed-size burst of received bytes into a small local store. Once the burst is complete, it sends the whole burst back to the UART transmitter, one byte at a time, in the order the bytes arrived.

The controller works in two phases. In the receive phase it waits for the data-available flag. When the flag is high, it copies the byte into the next free slot and increments a clocked byte counter. It then raises the receive acknowledge for a single cycle so that the UART clears its flag. When the counter reaches the burst depth, the controller enters the send phase. In the send phase it issues a one-cycle write strobe for each stored byte, and it does so only while the transmitter reports empty. After the last write it clears the counter and the read position and returns to the receive phase.

The current count is always visible on an 8-bit status output. A synchronous reset abandons any partial burst.

Top module: `burst_echo_ctrl`

## Requirements
- R1: While the controller waits for a byte (receive phase, data-available low), both the receive acknowledge and the write strobe stay low, and the two are never high in the same cycle.
- R2: When data-available is high in the receive phase, the byte is captured at that clock edge, and the receive acknowledge is high for exactly the one following cycle.
- R3: The status output carries the count of bytes held in the current burst as an unsigned binary value. It rises by exactly one per acknowledged byte and never exceeds the burst depth (default 4).
- R4: After the fourth byte is acknowledged the controller enters the send phase. During that phase a high data-available flag is not acknowledged, and that byte stays pending until the receive phase resumes.
- R5: Each write strobe is high for one cycle, is issued only in a cycle where the transmitter-empty flag is high, and presents the byte on the transmit data output in that same cycle.
- R6: The bytes of a burst are written back in the order they were received: slot 0 first, then 1, 2 and 3.
- R7: In the cycle after the last byte of a burst is written, the status output reads 0 and the controller is back in the receive phase. A pending byte is then captured as the first byte of the next burst.
- R8: A synchronous active-high reset clears the count to 0, drops both strobes and returns the controller to the receive-waiting state. Bytes from a partial burst are never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Byte presented by the UART receiver |
| rx_avail | input | 1 | High while a new received byte is present |
| rx_ack | output | 1 | One-cycle acknowledge of a captured byte |
| tx_byte | output | 8 | Byte offered to the UART transmitter |
| tx_wr | output | 1 | One-cycle strobe that starts a transmission |
| tx_empty | input | 1 | High when the transmitter can accept a byte |
| byte_count | output | 8 | Bytes held in the current burst, unsigned |

## Verification
The bench runs many bursts with all-zero, all-one and arithmetic byte patterns, under several transmitter busy lengths. A design that counted bytes in combinational logic, or that counted one byte more than once, would show the wrong value on the status output or would start the send phase early. The bench presents a byte while the controller is still echoing. A design that acknowledged that byte would lose it, or would overwrite a slot that had not yet been sent. The bench also resets the controller in the middle of a burst. A design that kept the old count would echo stale bytes, and a design that ignored the empty flag or left the strobe high would show overlapping writes in the transmitter model.

// File: rtl/burst_echo_pkg.sv
package burst_echo_pkg;

    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,
        PH_ACK  = 2'd1,
        PH_SEND = 2'd2,
        PH_HOLD = 2'd3
    } phase_t;

    typedef struct packed {
        logic ack;
        logic wr;
        logic capture;
    } ctl_t;

    function automatic int idx_width(input int depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/echo_store.sv
module echo_store #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && wr_idx == IDX_W'(g)) begin
                slots[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = slots[k];
        end
    end
endmodule

// File: rtl/echo_counter.sv
module echo_counter #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] rd_idx,
    output logic             full,
    output logic             last_rd
);
    localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    assign full    = (cnt == FULL_VAL);
    assign last_rd = (rd_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            rd_idx <= '0;
        end else if (adv) begin
            if (last_rd) begin
                cnt    <= '0;
                rd_idx <= '0;
            end else begin
                rd_idx <= rd_idx + 1'b1;
            end
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/echo_fsm.sv
module echo_fsm
    import burst_echo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_avail,
    input  logic tx_empty,
    input  logic full,
    input  logic last_rd,
    output ctl_t ctl
);
    phase_t ph, ph_nx;

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_WAIT;
        else     ph <= ph_nx;
    end

    always_comb begin
        ctl   = '0;
        ph_nx = ph;
        unique case (ph)
            PH_WAIT: begin
                if (rx_avail) begin
                    ctl.capture = 1'b1;
                    ph_nx       = PH_ACK;
                end
            end
            PH_ACK: begin
                ctl.ack = 1'b1;
                ph_nx   = full ? PH_SEND : PH_WAIT;
            end
            PH_SEND: begin
                if (tx_empty) begin
                    ctl.wr = 1'b1;
                    ph_nx  = last_rd ? PH_WAIT : PH_HOLD;
                end
            end
            PH_HOLD: ph_nx = PH_SEND;
            default: ph_nx = PH_WAIT;
        endcase
    end
endmodule

// File: rtl/burst_echo_ctrl.sv
module burst_echo_ctrl
    import burst_echo_pkg::*;
#(
    parameter int W      = 8,
    parameter int DEPTH  = 4,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      rx_byte,
    input  logic              rx_avail,
    output logic              rx_ack,
    output logic [W-1:0]      tx_byte,
    output logic              tx_wr,
    input  logic              tx_empty,
    output logic [STAT_W-1:0] byte_count
);
    localparam int IDX_W = idx_width(DEPTH);
    localparam int CNT_W = cnt_width(DEPTH);

    ctl_t             ctl;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] rd_idx;
    logic             full;
    logic             last_rd;

    echo_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rx_avail (rx_avail),
        .tx_empty (tx_empty),
        .full     (full),
        .last_rd  (last_rd),
        .ctl      (ctl)
    );

    echo_counter #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc     (ctl.capture),
        .adv     (ctl.wr),
        .cnt     (cnt),
        .rd_idx  (rd_idx),
        .full    (full),
        .last_rd (last_rd)
    );

    echo_store #(.W(W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .we      (ctl.capture),
        .wr_idx  (cnt[IDX_W-1:0]),
        .wr_data (rx_byte),
        .rd_idx  (rd_idx),
        .rd_data (tx_byte)
    );

    assign rx_ack     = ctl.ack;
    assign tx_wr      = ctl.wr;
    assign byte_count = STAT_W'(cnt);
endmodule

// File: rtl/burst_echo_chk.sv
module burst_echo_chk #(
    parameter int DEPTH  = 4,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_ack,
    input logic              tx_wr,
    input logic              tx_empty,
    input logic [STAT_W-1:0] byte_count
);
    AST_NO_MIX: assert property (@(posedge clk) disable iff (rst)
        !(rx_ack && tx_wr)); // R1
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_ack |=> !rx_ack); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ack) |-> byte_count == STAT_W'($past(byte_count) + 1'b1)); // R3
    AST_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
        byte_count <= STAT_W'(DEPTH)); // R3
    AST_SEND_FULL: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> byte_count == STAT_W'(DEPTH)); // R4
    AST_WR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_wr |-> tx_empty); // R5
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_wr |=> !tx_wr); // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (byte_count == '0 && !tx_wr)); // R8
endmodule

bind burst_echo_ctrl burst_echo_chk #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_ack     (rx_ack),
    .tx_wr      (tx_wr),
    .tx_empty   (tx_empty),
    .byte_count (byte_count)
);

// File: tb/tb_burst_echo_ctrl.sv
module tb_burst_echo_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_avail = 1'b0;
    logic       rx_ack;
    logic [7:0] tx_byte;
    logic       tx_wr;
    logic       tx_empty;
    logic [7:0] byte_count;

    int total = 0;
    int bad = 0;
    int busy_len = 1;
    int busy = 0;
    int tx_total = 0;
    int overlap = 0;
    logic       wr_prev = 1'b0;
    logic [7:0] tx_log [256];

    always #4 clk = ~clk;

    burst_echo_ctrl dut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_avail(rx_avail),
        .rx_ack(rx_ack), .tx_byte(tx_byte), .tx_wr(tx_wr),
        .tx_empty(tx_empty), .byte_count(byte_count)
    );

    // transmitter model
    always @(posedge clk) begin
        wr_prev <= tx_wr;
        if (tx_wr && wr_prev) overlap <= overlap + 1;
        if (rst) begin
            tx_empty <= 1'b1;
            busy     <= 0;
        end else if (tx_wr) begin
            if (!tx_empty) overlap <= overlap + 1;
            tx_log[tx_total[7:0]] <= tx_byte;
            tx_total <= tx_total + 1;
            tx_empty <= 1'b0;
            busy     <= busy_len;
        end else if (busy > 1) begin
            busy <= busy - 1;
        end else if (busy == 1) begin
            busy     <= 0;
            tx_empty <= 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int b, input int i);
        if (b == 0) return 8'h00;
        if (b == 1) return 8'hFF;
        return 8'((b * 53 + i * 29 + 7) & 255);
    endfunction

    // present one byte and wait for its acknowledge
    task automatic push(input logic [7:0] v, input int exp_cnt);
        int n = 0;
        @(negedge clk);
        rx_byte  = v;
        rx_avail = 1'b1;
        while (!rx_ack && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R2 ack seen", int'(rx_ack), 1);
        chk("R3 count", int'(byte_count), exp_cnt);
        rx_avail = 1'b0;
        @(negedge clk);
        chk("R2 ack one cycle", int'(rx_ack), 0);
    endtask

    task automatic wait_tx(input int target);
        int n = 0;
        while (tx_total < target && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R5 writes issued", tx_total, target);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog act=running exp=done");
        total++;
        bad++;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk("R8 reset count", int'(byte_count), 0);
        chk("R1 reset ack", int'(rx_ack), 0);
        chk("R1 reset wr", int'(tx_wr), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 idle ack", int'(rx_ack), 0);
        chk("R1 idle wr", int'(tx_wr), 0);

        // sweep of bursts with varied patterns and transmitter speeds
        for (int b = 0; b < 8; b++) begin
            busy_len = 1 + (b % 4);
            base = tx_total;
            for (int i = 0; i < 4; i++) push(pat(b, i), i + 1);
            wait_tx(base + 4);
            for (int i = 0; i < 4; i++)
                chk("R6 order", int'(tx_log[(base + i) & 255]), int'(pat(b, i)));
            chk("R7 count cleared", int'(byte_count), 0);
        end

        // byte offered during send phase is held, then starts next burst
        busy_len = 3;
        base = tx_total;
        for (int i = 0; i < 4; i++) push(pat(20, i), i + 1);
        rx_byte  = 8'hA5;
        rx_avail = 1'b1;
        while (tx_total < base + 4) begin
            chk("R4 no ack in send", int'(rx_ack), 0);
            @(negedge clk);
        end
        chk("R7 count after last write", int'(byte_count), 0);
        begin
            int n = 0;
            while (!rx_ack && n < 50) begin
                @(negedge clk);
                n++;
            end
        end
        chk("R7 held byte taken", int'(rx_ack), 1);
        chk("R7 held byte count", int'(byte_count), 1);
        rx_avail = 1'b0;
        for (int i = 0; i < 4; i++)
            chk("R6 order held burst", int'(tx_log[(base + i) & 255]), int'(pat(20, i)));
        base = tx_total;
        for (int i = 1; i < 4; i++) push(pat(21, i), i + 1);
        wait_tx(base + 4);
        chk("R7 held first", int'(tx_log[base & 255]), 8'hA5);
        for (int i = 1; i < 4; i++)
            chk("R6 order after held", int'(tx_log[(base + i) & 255]), int'(pat(21, i)));

        // reset in the middle of a burst
        base = tx_total;
        push(8'h11, 1);
        push(8'h22, 2);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R8 count cleared", int'(byte_count), 0);
        chk("R8 ack low", int'(rx_ack), 0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) push(pat(30, i), i + 1);
        wait_tx(base + 4);
        repeat (20) @(negedge clk);
        chk("R8 no stale writes", tx_total, base + 4);
        for (int i = 0; i < 4; i++)
            chk("R8 fresh burst", int'(tx_log[(base + i) & 255]), int'(pat(30, i)));

        chk("R5 no overlap", overlap, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule